// File: doc/BRIEF.md
# Phased Set-Associative Load/Store Cache

This block is a first-level data cache that serves byte loads and byte stores from a core-side request port. It holds 4 KB in 64 sets of four 16-byte lines. Each access is split into two phases: the first cycle compares the stored tags of the addressed set against the request, and the next cycle touches only the one data way that matched. This saves reading all four ways of data on every access. Replacement within a set uses a square bit matrix per set that records the order in which the ways were used.

Every store is also sent to the next level over a write-through channel, so lines are never dirty and evicting one causes no downstream write. On a miss, the cache asks the next level for the whole line only after its own lookup has failed. The line is installed in the chosen way, and the access is then replayed through the tag phase. This applies to stores too: a store miss first brings the line in and then writes its byte into it. Address translation happens outside the block; `req_addr` is already the address the cache indexes and tags.

All data movement uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so a requester that sees it low must hold its request. `rsp_valid` is a one-cycle pulse and cannot be stalled. Downstream, `fill_req_valid` and `wt_valid` stay high with a constant payload until the next level raises the matching ready. `fill_valid` carries the line for one cycle and is always accepted.

Top module: `l1_phased_cache`

## Requirements
- R1: Address bits [3:0] select the byte in a line, bits [9:4] select one of 64 sets, and the bits above are the tag. Each set holds four ways.
- R2: A load that hits raises `rsp_valid` with its byte in the second cycle after the cycle in which it is accepted.
- R3: After a request is accepted, `req_ready` stays low until that request's `rsp_valid` cycle, including during any line fill and replay. `req_ready` is high after reset.
- R4: A fill request goes downstream only after a tag lookup has missed. An access that hits causes no fill request.
- R5: `fill_req_addr` is the request address with its low four bits cleared. Byte b of the line sits in `fill_data[8b+7:8b]`. After the fill, the replayed access returns the addressed byte.
- R6: Every store, whether it hits or misses, produces exactly one write-through transfer. The transfer carries the store's full byte address and data. The store's response comes after the next level accepts that transfer.
- R7: A store miss fills the line first and then writes the byte into the cache. Later loads of that line hit, return the stored byte, and return the filled values for the other bytes.
- R8: On a miss, the cache fills an invalid way of the set if one exists, otherwise the least recently used way. Both hits and replays count as uses.
- R9: Eviction never produces a downstream write. Only stores drive `wt_valid`.
- R10: While `fill_req_valid` or `wt_valid` is high and its ready is low, the valid stays high and its payload is unchanged in the next cycle.
- R11: Reset leaves all lines invalid and all valid outputs low, so the first access to any address after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, able to take a request |
| req_write | input | 1 | 1 = byte store, 0 = byte load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Store byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Load byte (store byte echoed for stores) |
| fill_req_valid | output | 1 | Line fetch request to next level |
| fill_req_ready | input | 1 | Next level accepts the fetch request |
| fill_req_addr | output | ADDR_W | Line-aligned fetch address |
| fill_valid | input | 1 | Fetched line present (one cycle) |
| fill_data | input | LINE_BYTES*8 | Fetched line, byte 0 in the low bits |
| wt_valid | output | 1 | Write-through transfer present |
| wt_ready | input | 1 | Next level accepts the write-through |
| wt_addr | output | ADDR_W | Store byte address |
| wt_data | output | 8 | Store byte |

## Verification
Embedded assertions check, on every cycle, that fill requests follow only a failed tag lookup and that the downstream valids and payloads hold under back-pressure. They also check that no response appears while the controller is taking requests, that a tag hit on a load is answered in the next cycle, that no two ways of a set match one tag, and that each matrix update leaves the touched way most recent. The order in which ways are evicted, write-allocate merging, and data correctness after refills can only be shown by the bench's scenarios. The same holds for the empty cache after reset and for the count of downstream fills and write-throughs per access. Those scenarios compare returned bytes and downstream traffic against a reference byte store and a hand-derived use order for one set.

// File: rtl/l1pc_pkg.sv
package l1pc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG,
    ST_DATA,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_WT,
    ST_DONE
  } l1pc_state_e;
endpackage

// File: rtl/l1pc_tag_array.sv
module l1pc_tag_array #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(SETS)-1:0] lk_set,
  input  logic [TAG_W-1:0]        lk_tag,
  output logic                    hit,
  output logic [$clog2(WAYS)-1:0] hit_way,
  output logic                    has_free,
  output logic [$clog2(WAYS)-1:0] free_way,
  input  logic                    wr_en,
  input  logic [$clog2(SETS)-1:0] wr_set,
  input  logic [$clog2(WAYS)-1:0] wr_way,
  input  logic [TAG_W-1:0]        wr_tag
);
  localparam int WAY_W = $clog2(WAYS);

  logic             valid_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  match_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          valid_q[s][w] <= 1'b0;
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    hit      = |match_vec;
    hit_way  = '0;
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) hit_way = WAY_W'(w);
      if (!valid_q[lk_set][w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  // A tag never lives in two ways of one set.
  assert_unique_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/l1pc_data_array.sv
module l1pc_data_array #(
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16
) (
  input  logic                          clk,
  input  logic [$clog2(SETS)-1:0]       rd_set,
  input  logic [$clog2(WAYS)-1:0]       rd_way,
  input  logic [$clog2(LINE_BYTES)-1:0] rd_off,
  output logic [7:0]                    rd_byte,
  input  logic                          fill_en,
  input  logic [LINE_BYTES*8-1:0]       fill_line,
  input  logic                          st_en,
  input  logic [7:0]                    st_byte,
  input  logic [$clog2(SETS)-1:0]       wr_set,
  input  logic [$clog2(WAYS)-1:0]       wr_way
);
  localparam int LINE_W = LINE_BYTES * 8;

  logic [LINE_W-1:0] line_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (fill_en)
      line_q[wr_set][wr_way] <= fill_line;
    else if (st_en)
      line_q[wr_set][wr_way][int'(rd_off) * 8 +: 8] <= st_byte;
  end

  assign rd_byte = line_q[rd_set][rd_way][int'(rd_off) * 8 +: 8];
endmodule

// File: rtl/l1pc_lru_matrix.sv
module l1pc_lru_matrix #(
  parameter int SETS = 64,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    touch_en,
  input  logic [$clog2(SETS)-1:0] touch_set,
  input  logic [$clog2(WAYS)-1:0] touch_way,
  input  logic [$clog2(SETS)-1:0] q_set,
  output logic [$clog2(WAYS)-1:0] lru_way
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);

  logic [WAYS-1:0] mat_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int r = 0; r < WAYS; r++)
          mat_q[s][r] <= '0;
    end else if (touch_en) begin
      for (int r = 0; r < WAYS; r++) begin
        if (r == int'(touch_way))
          mat_q[touch_set][r] <= ~(WAYS'(1) << touch_way);
        else
          mat_q[touch_set][r][touch_way] <= 1'b0;
      end
    end
  end

  always_comb begin
    lru_way = '0;
    for (int r = WAYS - 1; r >= 0; r--)
      if (mat_q[q_set][r] == '0) lru_way = WAY_W'(r);
  end

  logic             chk_en_q;
  logic [SET_W-1:0] chk_set_q;
  logic [WAY_W-1:0] chk_way_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_en_q  <= 1'b0;
      chk_set_q <= '0;
      chk_way_q <= '0;
    end else begin
      chk_en_q  <= touch_en;
      chk_set_q <= touch_set;
      chk_way_q <= touch_way;
    end
  end

  // The way just used is most recent: its row has every other bit set.
  assert_touch_mru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_q |-> ($countones(mat_q[chk_set_q][chk_way_q]) == WAYS - 1));

  // The way just used is never chosen as victim of that set.
  assert_mru_not_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_q && q_set == chk_set_q && WAYS > 1) |-> (lru_way != chk_way_q));
endmodule

// File: rtl/l1_phased_cache.sv
module l1_phased_cache #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 64,
  parameter int WAYS       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [7:0]              req_wdata,
  output logic                    rsp_valid,
  output logic [7:0]              rsp_rdata,
  output logic                    fill_req_valid,
  input  logic                    fill_req_ready,
  output logic [ADDR_W-1:0]       fill_req_addr,
  input  logic                    fill_valid,
  input  logic [LINE_BYTES*8-1:0] fill_data,
  output logic                    wt_valid,
  input  logic                    wt_ready,
  output logic [ADDR_W-1:0]       wt_addr,
  output logic [7:0]              wt_data
);
  import l1pc_pkg::*;

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  l1pc_state_e       state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic [WAY_W-1:0]  way_q;

  logic [OFF_W-1:0]  cur_off;
  logic [IDX_W-1:0]  cur_set;
  logic [TAG_W-1:0]  cur_tag;

  logic              tag_hit, has_free;
  logic [WAY_W-1:0]  hit_way, free_way, lru_way;
  logic [7:0]        rd_byte;
  logic              install, st_apply, touch;

  assign cur_off = addr_q[OFF_W-1:0];
  assign cur_set = addr_q[OFF_W +: IDX_W];
  assign cur_tag = addr_q[ADDR_W-1 -: TAG_W];

  assign install  = (state_q == ST_FILL_WAIT) && fill_valid;
  assign touch    = (state_q == ST_DATA);
  assign st_apply = touch && wr_q;

  l1pc_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_set(cur_set), .lk_tag(cur_tag),
    .hit(tag_hit), .hit_way(hit_way),
    .has_free(has_free), .free_way(free_way),
    .wr_en(install), .wr_set(cur_set), .wr_way(way_q), .wr_tag(cur_tag)
  );

  l1pc_data_array #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)) u_data (
    .clk(clk),
    .rd_set(cur_set), .rd_way(way_q), .rd_off(cur_off), .rd_byte(rd_byte),
    .fill_en(install), .fill_line(fill_data),
    .st_en(st_apply), .st_byte(wdata_q),
    .wr_set(cur_set), .wr_way(way_q)
  );

  l1pc_lru_matrix #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch), .touch_set(cur_set), .touch_way(way_q),
    .q_set(cur_set), .lru_way(lru_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      way_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          state_q <= ST_TAG;
        end
        ST_TAG: begin
          if (tag_hit) begin
            way_q   <= hit_way;
            state_q <= ST_DATA;
          end else begin
            way_q   <= has_free ? free_way : lru_way;
            state_q <= ST_FILL_REQ;
          end
        end
        ST_FILL_REQ:  if (fill_req_ready) state_q <= ST_FILL_WAIT;
        ST_FILL_WAIT: if (fill_valid) state_q <= ST_TAG;
        ST_DATA:      state_q <= wr_q ? ST_WT : ST_IDLE;
        ST_WT:        if (wt_ready) state_q <= ST_DONE;
        ST_DONE:      state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign rsp_valid      = (touch && !wr_q) || (state_q == ST_DONE);
  assign rsp_rdata      = wr_q ? wdata_q : rd_byte;
  assign fill_req_valid = (state_q == ST_FILL_REQ);
  assign fill_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wt_valid       = (state_q == ST_WT);
  assign wt_addr        = addr_q;
  assign wt_data        = wdata_q;

  assert_look_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req_valid) |-> $past(state_q == ST_TAG && !tag_hit));

  assert_hit_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAG && tag_hit && !wr_q) |=> (rsp_valid && rsp_rdata == rd_byte));

  assert_busy_no_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_fill_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));

  assert_wt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_valid && !wt_ready) |=> (wt_valid && $stable(wt_addr) && $stable(wt_data)));

  assert_wt_only_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wt_valid) |-> $past(st_apply));
endmodule

// File: tb/l1_phased_cache_tb.sv
module l1_phased_cache_tb;
  localparam int AW = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]   req_wdata = '0;
  logic         req_ready, rsp_valid;
  logic [7:0]   rsp_rdata;
  logic         fill_req_valid, fill_req_ready = 1'b0;
  logic [AW-1:0] fill_req_addr;
  logic         fill_valid = 1'b0;
  logic [127:0] fill_data = '0;
  logic         wt_valid, wt_ready = 1'b0;
  logic [AW-1:0] wt_addr;
  logic [7:0]   wt_data;

  always #2.5 clk = ~clk;

  l1_phased_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr), .fill_valid(fill_valid), .fill_data(fill_data),
    .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_addr(wt_addr), .wt_data(wt_data)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Downstream memory (written by write-through) and reference store (written by bench).
  logic [7:0] ds_mem  [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] base_byte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] ds_byte(input logic [AW-1:0] a);
    return ds_mem.exists(int'(a)) ? ds_mem[int'(a)] : base_byte(a);
  endfunction

  function automatic logic [7:0] ref_byte(input logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : base_byte(a);
  endfunction

  // Next-level responder: all activity on the falling edge.
  int          cyc = 0, fill_cnt = 0, wt_cnt = 0, pend = 0;
  logic [AW-1:0] pend_addr = '0, last_wt_addr = '0, prev_fa = '0, prev_wa = '0;
  logic [7:0]  last_wt_data = '0, prev_wd = '0;
  logic        prev_fv = 1'b0, prev_fr = 1'b0, prev_wv = 1'b0, prev_wr = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_fv = 1'b0; prev_wv = 1'b0; pend = 0; fill_valid = 1'b0;
    end else begin
      // R10: held requests keep their payload.
      if (prev_fv && !prev_fr)
        check(fill_req_valid && fill_req_addr == prev_fa, "R10 fill hold", fill_req_addr, prev_fa);
      if (prev_wv && !prev_wr)
        check(wt_valid && wt_addr == prev_wa && wt_data == prev_wd, "R10 wt hold", wt_addr, prev_wa);
      cyc++;
      fill_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          fill_valid = 1'b1;
          for (int b = 0; b < 16; b++)
            fill_data[b*8 +: 8] = ds_byte({pend_addr[AW-1:4], 4'(b)});
        end
      end
      fill_req_ready = (cyc % 3 == 2);
      wt_ready       = (cyc % 2 == 1);
      if (fill_req_valid && fill_req_ready) begin
        fill_cnt++;
        pend_addr = fill_req_addr;
        pend = 3;
      end
      if (wt_valid && wt_ready) begin
        wt_cnt++;
        last_wt_addr = wt_addr;
        last_wt_data = wt_data;
        ds_mem[int'(wt_addr)] = wt_data;
      end
      prev_fv = fill_req_valid; prev_fr = fill_req_ready; prev_fa = fill_req_addr;
      prev_wv = wt_valid; prev_wr = wt_ready; prev_wa = wt_addr; prev_wd = wt_data;
    end
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [7:0] wd,
                        output logic [7:0] rd, output int lat, output bit busy_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; busy_ok = 1'b1;
    while (!rsp_valid && lat < 5000) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    if (req_ready) busy_ok = 1'b0;
    rd = rsp_rdata;
  endtask

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic          miss;
  } vec_t;

  // Set 0 uses tags 0..4 (address bits [9:4] = 0) to drive the LRU order (R1, R8).
  localparam vec_t VEC [19] = '{
    '{1'b0, 16'h0000, 8'h00, 1'b1},  // way0
    '{1'b0, 16'h0003, 8'h00, 1'b0},
    '{1'b0, 16'h0400, 8'h00, 1'b1},  // way1
    '{1'b0, 16'h0800, 8'h00, 1'b1},  // way2
    '{1'b0, 16'h0C00, 8'h00, 1'b1},  // way3
    '{1'b0, 16'h0005, 8'h00, 1'b0},  // 0x0000 now most recent
    '{1'b0, 16'h1000, 8'h00, 1'b1},  // evicts 0x0400
    '{1'b0, 16'h0000, 8'h00, 1'b0},
    '{1'b0, 16'h0800, 8'h00, 1'b0},
    '{1'b0, 16'h0400, 8'h00, 1'b1},  // evicts 0x0C00
    '{1'b0, 16'h0C00, 8'h00, 1'b1},  // evicts 0x1000
    '{1'b0, 16'h1000, 8'h00, 1'b1},  // evicts 0x0000
    '{1'b1, 16'h2345, 8'hA7, 1'b1},  // store miss, allocate
    '{1'b0, 16'h2345, 8'h00, 1'b0},
    '{1'b0, 16'h2341, 8'h00, 1'b0},
    '{1'b1, 16'h2346, 8'h19, 1'b0},  // store hit
    '{1'b0, 16'h2346, 8'h00, 1'b0},
    '{1'b0, 16'h0010, 8'h00, 1'b1},  // set 1
    '{1'b0, 16'h001F, 8'h00, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int lat, f0, w0;
    bit busy_ok;

    repeat (4) @(negedge clk);
    // R11: idle outputs after reset (R3: ready high).
    check(req_ready === 1'b1, "R3 reset ready", req_ready, 1);
    check(rsp_valid === 1'b0 && fill_req_valid === 1'b0 && wt_valid === 1'b0,
          "R11 reset valids", {rsp_valid, fill_req_valid, wt_valid}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 19; i++) begin
      f0 = fill_cnt; w0 = wt_cnt;
      if (VEC[i].wr) ref_mem[int'(VEC[i].addr)] = VEC[i].wdata;
      access(VEC[i].wr, VEC[i].addr, VEC[i].wdata, rd, lat, busy_ok);
      check(fill_cnt - f0 == int'(VEC[i].miss), "R4/R8 R1 fill count", fill_cnt - f0, VEC[i].miss);
      check(busy_ok, "R3 ready low while busy", 0, 1);
      if (VEC[i].miss)
        check(pend_addr == {VEC[i].addr[AW-1:4], 4'h0}, "R5 fill address", pend_addr,
              {VEC[i].addr[AW-1:4], 4'h0});
      if (VEC[i].wr) begin
        check(wt_cnt - w0 == 1, "R6 one write-through", wt_cnt - w0, 1);
        check(last_wt_addr == VEC[i].addr && last_wt_data == VEC[i].wdata,
              "R6 write-through payload", {last_wt_addr, last_wt_data}, {VEC[i].addr, VEC[i].wdata});
      end else begin
        check(wt_cnt == w0, "R9 no write on load/evict", wt_cnt - w0, 0);
        check(rd == ref_byte(VEC[i].addr), "R5/R7 load data", rd, ref_byte(VEC[i].addr));
        if (!VEC[i].miss) check(lat == 2, "R2 hit latency", lat, 2);
      end
    end

    // R11: reset empties the cache; R7: the stored byte returns from below.
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    f0 = fill_cnt;
    access(1'b0, 16'h2345, 8'h00, rd, lat, busy_ok);
    check(fill_cnt - f0 == 1, "R11 miss after reset", fill_cnt - f0, 1);
    check(rd == 8'hA7, "R7 write-through data refilled", rd, 8'hA7);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule